// File: doc/BRIEF.md
# Power-State Control and Status Register

This block holds the 16-bit power-management control and status word of a storage-controller function, together with the logic that acts on it. Configuration writes, qualified by two byte-lane enables, move the function between the fully active state D0 and the low-power state D3hot. The same writes arm or disarm wake signalling and clear a pending wake request. A wake event input sets the pending flag. While both the flag and the arm bit are set, an active-low wake request output is held low.

In D3hot the block raises a gate that blocks I/O and memory decode, and it raises an interrupt mask. Configuration reads and writes still work in this state. A read-only option, fixed by a parameter, selects whether a return from D3hot to D0 fires a one-clock internal reset pulse. There are two resets. A cold reset clears everything. A bus reset always returns the power state to D0, but it keeps the wake context when wake support is built in and armed.

Top module: `pwr_mgmt_csr`

## Requirements
- R1: After a cold reset the read word is 0x0008 when NO_SOFT_RST=1 and 0x0000 when it is 0. Bit 3 always reads the NO_SOFT_RST value.
- R2: Bit 15 (pending wake) is set by pmeEvent. A write with byte lane 1 enabled and data bit 15 at 1 clears it. A write with data bit 15 at 0 leaves it unchanged.
- R3: If pmeEvent and a clearing write to bit 15 occur in the same cycle, bit 15 ends up set.
- R4: Bit 8 (wake arm) takes data bit 8 on every write with byte lane 1 enabled. pmeN is 0 exactly when bits 15 and 8 are both 1.
- R5: Bits 1:0 (power state, 00 = D0, 11 = D3hot) take data bits 1:0 on a write with byte lane 0 enabled. A write of 01 or 10 leaves the field unchanged.
- R6: ioMemBlock and intrMask are 1 exactly when bits 1:0 read 11.
- R7: With NO_SOFT_RST=0, an accepted write from 11 to 00 makes softRstPulse 1 for exactly the next cycle. With NO_SOFT_RST=1, or on any other transition, softRstPulse stays 0.
- R8: While busRstN is low, bits 1:0 become 00. Bits 15 and 8 keep their values if bit 8 is 1 and wake support is built in; otherwise both are cleared.
- R9: Reserved bits 14:9, 7:4 and 2 read 0, and writes to them are ignored.
- R10: A write with a lane enable at 0 leaves that lane's fields unchanged. Lane 0 holds bits 7:0 and lane 1 holds bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Cold reset, asynchronous, active low |
| busRstN | input | 1 | Bus reset, synchronous, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgByteEn | input | 2 | Byte-lane enables for the write |
| cfgWrData | input | 16 | Write data |
| cfgRdData | output | 16 | Current register value |
| pmeEvent | input | 1 | Wake event, one cycle per event |
| pmeN | output | 1 | Wake request, active low |
| ioMemBlock | output | 1 | Blocks I/O and memory decode in D3hot |
| intrMask | output | 1 | Blocks interrupts in D3hot |
| softRstPulse | output | 1 | Internal reset pulse on a D3hot-to-D0 return |

## Verification
The assertions check the following on every cycle:
- the wake output agrees with the read word;
- the decode gate and interrupt mask agree with the power state;
- the power-state field never holds an illegal code;
- the reserved bits stay zero;
- clears and events act in the cycle after they occur;
- every reset pulse lasts one cycle and follows a D3hot-to-D0 step.

Some behaviour only the bench scenarios can show. These are the absence of a pulse on the variant with the option bit set, and the ignoring of illegal state codes and of disabled byte lanes. They also include the two outcomes of a bus reset, where wake context is kept or lost depending on the arm bit.

// File: rtl/pwr_mgmt_pkg.sv
package pwr_mgmt_pkg;
  localparam int REG_W = 16;
  localparam int LANES = REG_W / 8;

  localparam int STS_BIT = 15;
  localparam int ARM_BIT = 8;
  localparam int NSR_BIT = 3;
  localparam int PS_LO   = 0;
  localparam int PS_W    = 2;

  localparam logic [PS_W-1:0] PS_D0    = 2'b00;
  localparam logic [PS_W-1:0] PS_D3HOT = 2'b11;

  localparam logic [REG_W-1:0] RSVD_MASK = 16'h7EF4;

  typedef struct packed {
    logic            psLoad;
    logic [PS_W-1:0] psNext;
    logic            armLoad;
    logic            armNext;
    logic            stsClear;
    logic            softRstReq;
  } pmStrobe_t;
endpackage

// File: rtl/pwr_mgmt_ctrl.sv
module pwr_mgmt_ctrl
  import pwr_mgmt_pkg::*;
#(
  parameter bit NO_SOFT_RST = 1'b1
) (
  input  logic             cfgWrEn,
  input  logic [LANES-1:0] cfgByteEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic [PS_W-1:0]  curPs,
  output pmStrobe_t        strobe
);
  logic [LANES-1:0] laneWr;
  logic [PS_W-1:0]  psReq;
  logic             psLegal;
  logic             unusedBits;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneWr[g] = cfgWrEn & cfgByteEn[g];
  end

  assign psReq   = cfgWrData[PS_LO +: PS_W];
  assign psLegal = (psReq == PS_D0) || (psReq == PS_D3HOT);

  assign unusedBits = ^(cfgWrData & RSVD_MASK) ^ cfgWrData[NSR_BIT];

  always_comb begin
    strobe            = '0;
    strobe.psLoad     = laneWr[PS_LO / 8] & psLegal;
    strobe.psNext     = psReq;
    strobe.armLoad    = laneWr[ARM_BIT / 8];
    strobe.armNext    = cfgWrData[ARM_BIT];
    strobe.stsClear   = laneWr[STS_BIT / 8] & cfgWrData[STS_BIT];
    strobe.softRstReq = strobe.psLoad && !NO_SOFT_RST &&
                        (curPs == PS_D3HOT) && (psReq == PS_D0);
  end
endmodule

// File: rtl/pwr_mgmt_dp.sv
module pwr_mgmt_dp
  import pwr_mgmt_pkg::*;
#(
  parameter bit PME_SUPPORT = 1'b1
) (
  input  logic            clk,
  input  logic            porN,
  input  logic            busRstN,
  input  logic            pmeEvent,
  input  pmStrobe_t       strobe,
  output logic [PS_W-1:0] psQ,
  output logic            armQ,
  output logic            stsQ,
  output logic            pulseQ
);
  logic keepCtx;

  assign keepCtx = PME_SUPPORT && armQ;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      psQ    <= PS_D0;
      armQ   <= 1'b0;
      stsQ   <= 1'b0;
      pulseQ <= 1'b0;
    end else if (!busRstN) begin
      psQ    <= PS_D0;
      pulseQ <= 1'b0;
      if (!keepCtx) begin
        armQ <= 1'b0;
        stsQ <= 1'b0;
      end
    end else begin
      if (strobe.psLoad) psQ <= strobe.psNext;
      if (strobe.armLoad) armQ <= strobe.armNext & PME_SUPPORT;
      if (pmeEvent && PME_SUPPORT) stsQ <= 1'b1;
      else if (strobe.stsClear) stsQ <= 1'b0;
      pulseQ <= strobe.softRstReq;
    end
  end
endmodule

// File: rtl/pwr_mgmt_csr.sv
module pwr_mgmt_csr
  import pwr_mgmt_pkg::*;
#(
  parameter bit NO_SOFT_RST = 1'b1,
  parameter bit PME_SUPPORT = 1'b1
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        busRstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgByteEn,
  input  logic [15:0] cfgWrData,
  output logic [15:0] cfgRdData,
  input  logic        pmeEvent,
  output logic        pmeN,
  output logic        ioMemBlock,
  output logic        intrMask,
  output logic        softRstPulse
);
  pmStrobe_t       strobe;
  logic [PS_W-1:0] psQ;
  logic            armQ;
  logic            stsQ;
  logic            pulseQ;
  logic            inD3;

  pwr_mgmt_ctrl #(.NO_SOFT_RST(NO_SOFT_RST)) u_ctrl (
    .cfgWrEn  (cfgWrEn),
    .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData),
    .curPs    (psQ),
    .strobe   (strobe)
  );

  pwr_mgmt_dp #(.PME_SUPPORT(PME_SUPPORT)) u_dp (
    .clk     (clk),
    .porN    (porN),
    .busRstN (busRstN),
    .pmeEvent(pmeEvent),
    .strobe  (strobe),
    .psQ     (psQ),
    .armQ    (armQ),
    .stsQ    (stsQ),
    .pulseQ  (pulseQ)
  );

  always_comb begin
    cfgRdData                   = '0;
    cfgRdData[STS_BIT]          = stsQ;
    cfgRdData[ARM_BIT]          = armQ;
    cfgRdData[NSR_BIT]          = NO_SOFT_RST;
    cfgRdData[PS_LO +: PS_W]    = psQ;
  end

  assign inD3         = (psQ == PS_D3HOT);
  assign ioMemBlock   = inD3;
  assign intrMask     = inD3;
  assign pmeN         = ~(stsQ & armQ);
  assign softRstPulse = pulseQ;
endmodule

// File: rtl/pwr_mgmt_checker.sv
module pwr_mgmt_checker #(
  parameter bit PME_SUPPORT = 1'b1
) (
  input logic        clk,
  input logic        porN,
  input logic        busRstN,
  input logic        cfgWrEn,
  input logic [1:0]  cfgByteEn,
  input logic [15:0] cfgWrData,
  input logic [15:0] cfgRdData,
  input logic        pmeEvent,
  input logic        pmeN,
  input logic        ioMemBlock,
  input logic        intrMask,
  input logic        softRstPulse
);
  p_pme_out_r4: assert property (@(posedge clk) disable iff (!porN || !busRstN)
    pmeN == !(cfgRdData[15] && cfgRdData[8]));

  p_d3_gate_r6: assert property (@(posedge clk) disable iff (!porN || !busRstN)
    (ioMemBlock == (cfgRdData[1:0] == 2'b11)) && (intrMask == ioMemBlock));

  p_ps_legal_r5: assert property (@(posedge clk) disable iff (!porN || !busRstN)
    cfgRdData[1:0] == 2'b00 || cfgRdData[1:0] == 2'b11);

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!porN || !busRstN)
    (cfgRdData & 16'h7EF4) == 16'h0000);

  p_w1c_r2: assert property (@(posedge clk) disable iff (!porN || !busRstN)
    (cfgWrEn && cfgByteEn[1] && cfgWrData[15] && !pmeEvent) |=> !cfgRdData[15]);

  p_evt_wins_r3: assert property (@(posedge clk) disable iff (!porN || !busRstN)
    (pmeEvent && PME_SUPPORT) |=> cfgRdData[15]);

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!porN || !busRstN)
    softRstPulse |=> !softRstPulse);

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!porN || !busRstN)
    softRstPulse |-> (cfgRdData[1:0] == 2'b00 && $past(cfgRdData[1:0]) == 2'b11));

  p_busrst_d0_r8: assert property (@(posedge clk) disable iff (!porN)
    !busRstN |=> cfgRdData[1:0] == 2'b00);
endmodule

bind pwr_mgmt_csr pwr_mgmt_checker #(.PME_SUPPORT(PME_SUPPORT)) u_chk (
  .clk(clk), .porN(porN), .busRstN(busRstN), .cfgWrEn(cfgWrEn),
  .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
  .pmeEvent(pmeEvent), .pmeN(pmeN), .ioMemBlock(ioMemBlock),
  .intrMask(intrMask), .softRstPulse(softRstPulse)
);

// File: tb/tb_pwr_mgmt_csr.sv
module tb_pwr_mgmt_csr;
  logic        clk = 1'b0;
  logic        porN, busRstN, cfgWrEn, pmeEvent;
  logic [1:0]  cfgByteEn;
  logic [15:0] cfgWrData;
  logic [15:0] rdA, rdB;
  logic        pmeNA, blkA, maskA, pulseA;
  logic        pmeNB, blkB, maskB, pulseB;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pwr_mgmt_csr #(.NO_SOFT_RST(1'b1)) dut (
    .clk(clk), .porN(porN), .busRstN(busRstN), .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(rdA),
    .pmeEvent(pmeEvent), .pmeN(pmeNA), .ioMemBlock(blkA),
    .intrMask(maskA), .softRstPulse(pulseA));

  pwr_mgmt_csr #(.NO_SOFT_RST(1'b0)) dutRst (
    .clk(clk), .porN(porN), .busRstN(busRstN), .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(rdB),
    .pmeEvent(pmeEvent), .pmeN(pmeNB), .ioMemBlock(blkB),
    .intrMask(maskB), .softRstPulse(pulseB));

  typedef struct packed {
    logic        wr;
    logic [1:0]  be;
    logic [15:0] data;
    logic        ev;
    logic [15:0] expRd;
    logic        expPmeN;
    logic        expBlk;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'b00, 16'h0000, 1'b0, 16'h0008, 1'b1, 1'b0}, // R1 idle
    '{1'b1, 2'b01, 16'h0003, 1'b0, 16'h000B, 1'b1, 1'b1}, // R5 R6 to D3hot
    '{1'b1, 2'b01, 16'h0001, 1'b0, 16'h000B, 1'b1, 1'b1}, // R5 01 ignored
    '{1'b1, 2'b11, 16'hFFFC, 1'b0, 16'h0108, 1'b1, 1'b0}, // R4 R9 arm, D0
    '{1'b0, 2'b00, 16'h0000, 1'b1, 16'h8108, 1'b0, 1'b0}, // R2 event
    '{1'b1, 2'b10, 16'h0000, 1'b0, 16'h8008, 1'b1, 1'b0}, // R2 R4 write 0
    '{1'b1, 2'b10, 16'h0100, 1'b0, 16'h8108, 1'b0, 1'b0}, // R4 rearm
    '{1'b1, 2'b01, 16'h8000, 1'b0, 16'h8108, 1'b0, 1'b0}, // R10 lane1 off
    '{1'b1, 2'b10, 16'h8100, 1'b1, 16'h8108, 1'b0, 1'b0}, // R3 collision
    '{1'b1, 2'b10, 16'h8100, 1'b0, 16'h0108, 1'b1, 1'b0}, // R2 clear
    '{1'b1, 2'b01, 16'h0002, 1'b0, 16'h0108, 1'b1, 1'b0}, // R5 10 ignored
    '{1'b1, 2'b11, 16'h0103, 1'b0, 16'h010B, 1'b1, 1'b1}  // R6 D3hot again
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic wr, logic [1:0] be, logic [15:0] d, logic ev);
    cfgWrEn = wr; cfgByteEn = be; cfgWrData = d; pmeEvent = ev;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = 2'b00; cfgWrData = '0; pmeEvent = 1'b0;
  endtask

  initial begin
    porN = 1'b0; busRstN = 1'b1; cfgWrEn = 1'b0; cfgByteEn = 2'b00;
    cfgWrData = '0; pmeEvent = 1'b0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    check("R1 reset word", rdA, 16'h0008);
    check("R1 reset word, option 0", rdB, 16'h0000);
    check("R1 reset outputs", {15'b0, pmeNA}, 16'h0001);
    check("R6 reset gates", {14'b0, blkA, maskA}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].wr, VECS[i].be, VECS[i].data, VECS[i].ev);
      check($sformatf("vector %0d word", i), rdA, VECS[i].expRd);
      check($sformatf("R4 vector %0d pmeN", i), {15'b0, pmeNA}, {15'b0, VECS[i].expPmeN});
      check($sformatf("R6 vector %0d gates", i), {14'b0, blkA, maskA},
            {14'b0, VECS[i].expBlk, VECS[i].expBlk});
    end

    // R7: D3hot to D0 return; both variants sit in D3hot here
    apply(1'b1, 2'b01, 16'h0000, 1'b0);
    check("R7 pulse with option 0", {15'b0, pulseB}, 16'h0001);
    check("R7 no pulse with option 1", {15'b0, pulseA}, 16'h0000);
    check("R7 state after return", rdA, 16'h0108);
    apply(1'b0, 2'b00, 16'h0000, 1'b0);
    check("R7 pulse lasts one cycle", {15'b0, pulseB}, 16'h0000);
    apply(1'b1, 2'b01, 16'h0000, 1'b0);
    check("R7 no pulse on D0 to D0", {15'b0, pulseB}, 16'h0000);

    // R8: bus reset with wake armed keeps context
    apply(1'b1, 2'b11, 16'h0103, 1'b0);
    apply(1'b0, 2'b00, 16'h0000, 1'b1);
    check("R8 setup", rdA, 16'h810B);
    busRstN = 1'b0;
    @(negedge clk);
    busRstN = 1'b1;
    check("R8 armed context kept", rdA, 16'h8108);
    check("R8 pmeN kept", {15'b0, pmeNA}, 16'h0000);
    check("R8 gates off", {14'b0, blkA, maskA}, 16'h0000);

    // R8: bus reset with wake disarmed clears status
    apply(1'b1, 2'b10, 16'h0000, 1'b0);
    check("R8 disarm", rdA, 16'h8008);
    busRstN = 1'b0;
    @(negedge clk);
    busRstN = 1'b1;
    check("R8 disarmed context cleared", rdA, 16'h0008);

    // R9: reserved-only write
    apply(1'b1, 2'b11, 16'h7EF4, 1'b0);
    check("R9 reserved write ignored", rdA, 16'h0008);
    apply(1'b1, 2'b11, 16'hFFFF, 1'b0);
    check("R9 all-ones write", rdA, 16'h010B);
    // R10: lane 0 disabled leaves power state
    apply(1'b1, 2'b10, 16'h0000, 1'b0);
    check("R10 lane0 off", rdA, 16'h000B);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
      wait (done);
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule